// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every observed cycle of a CPU bus and raises a break request when a cycle meets the conditions software has programmed. It has two channels, A and B. Each channel compares the bus address and the address-space identifier with its own programmed values. A per-bit address mask and an identifier-ignore option select which parts take part in the comparison. Channel B can also compare the data bus under a data mask. Each channel is limited by a cycle-type field (instruction fetch, data access or either) and a direction field (read, write or either). When either field is zero, the channel is switched off.

A break request is a one-cycle pulse. It carries a tag that gives the channel that fired and whether the break is taken before or after the instruction executes. Each channel also has a sticky match flag that only software can clear. In chained operation, channel B breaks only when it matches after a channel A match seen in an earlier cycle. In that mode only channel B's flag is ever set. Software reaches all state through a plain register write strobe and a combinational read port.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads zero, both flags are low, and no break is raised, even for a bus cycle whose address and identifier are all zero.
- R2: Channel configuration register (A at 3, B at 7) bits[1:0] select the cycle type: 01 fetch, 10 data access, 11 either. Bits[3:2] select the direction: 01 read, 10 write, 11 either. A value of 00 in either field means the channel never matches.
- R3: Address mask registers (A at 1, B at 5): a mask bit of 1 leaves that address bit out of the comparison with the address registers (A at 0, B at 4).
- R4: The identifier registers (A at 2, B at 6) must equal the bus identifier, unless configuration bit 4 is set, in which case the identifier is ignored.
- R5: When control bit 2 is set and the cycle is a data access, channel B also requires bus data to equal register 8 on every bit where register 9 holds a 0. Fetch cycles, and any cycle while control bit 2 is clear, ignore the data.
- R6: A match in a valid bus cycle gives brk_req high for exactly the one cycle after it, with brk_chan 0 for A and 1 for B.
- R7: brk_post equals the firing channel's post-execution control bit (bit 0 for A, bit 1 for B) on fetch matches, and is 1 on data-access matches.
- R8: Flag register 11 holds flag A in bit 0 and flag B in bit 1. A channel's break sets its flag. Writing 0 to a bit clears it, and writing 1 has no effect. A set in the same cycle as a clearing write wins.
- R9: With control bit 3 (sequential) set, a break is raised only when channel B matches in a cycle after an earlier channel A match. A B match before A, or in the same cycle as A, gives no break.
- R10: In sequential mode channel A never breaks and flag A is never set. The chained break reports channel B and sets flag B.
- R11: The remembered channel A match is dropped when the chained break fires and when sequential mode is switched off.
- R12: In independent mode, when both channels match in one cycle, a single break is raised with the channel A tag, and both flags are set.
- R13: The registers read back what was written, limited to their implemented bits: 5 bits for configuration and 4 bits for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| bus_valid | input | 1 | Observed bus cycle is valid |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Bus address |
| bus_id | input | IW | Address-space identifier |
| bus_data | input | DW | Bus data |
| brk_req | output | 1 | One-cycle break request |
| brk_chan | output | 1 | Firing channel, 0 A / 1 B |
| brk_post | output | 1 | 1 post-execution, 0 pre-execution |
| flag_a | output | 1 | Sticky match flag, channel A |
| flag_b | output | 1 | Sticky match flag, channel B |

## Verification
The hardest case to reach from the ports is the hidden "A already seen" state of chained mode. Nothing reads it out directly; it shows only through whether a later B match breaks. The stimulus sets it with an A-only cycle, then either fires B, turns sequential mode off and on, or gives B first. Each time, a following B cycle shows whether the state was kept or dropped. To cover the same-cycle rule, channel B is reprogrammed onto channel A's address so that one bus cycle hits both. That cycle must not break, and the next one must.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NCH  = 2;
    localparam int RA_W = 4;

    // per-channel register offsets; channel c lives at c*CH_STRIDE
    localparam logic [RA_W-1:0] OFF_ADDR  = 4'd0;
    localparam logic [RA_W-1:0] OFF_AMSK  = 4'd1;
    localparam logic [RA_W-1:0] OFF_ID    = 4'd2;
    localparam logic [RA_W-1:0] OFF_CFG   = 4'd3;
    localparam int              CH_STRIDE = 4;

    localparam logic [RA_W-1:0] RA_BDATA = 4'd8;
    localparam logic [RA_W-1:0] RA_BDMSK = 4'd9;
    localparam logic [RA_W-1:0] RA_CTRL  = 4'd10;
    localparam logic [RA_W-1:0] RA_FLAGS = 4'd11;

    typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;

    typedef struct packed {
        logic       id_ign;
        logic [1:0] dir;   // 01 read, 10 write, 11 either
        logic [1:0] cyc;   // 01 fetch, 10 data, 11 either
    } chan_cfg_t;

    typedef struct packed {
        logic seq;
        logic data_en;
        logic post_b;
        logic post_a;
    } ctrl_t;

    typedef struct packed {
        logic  req;
        chan_e chan;
        logic  post;
    } brk_tag_t;

    localparam int CFG_W  = $bits(chan_cfg_t);
    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [RA_W-1:0] reg_of(input int c, input logic [RA_W-1:0] off);
        return RA_W'(c * CH_STRIDE) + off;
    endfunction

    function automatic logic kind_ok(input chan_cfg_t c, input logic fetch, input logic write);
        logic cyc_hit, dir_hit;
        cyc_hit = fetch ? c.cyc[0] : c.cyc[1];
        dir_hit = write ? c.dir[1] : c.dir[0];
        return cyc_hit & dir_hit;
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int RW = 32,
    parameter int AW = 32,
    parameter int IW = 8,
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [RA_W-1:0]          addr,
    input  logic [RW-1:0]            wdata,
    output logic [RW-1:0]            rdata,
    output logic [NCH-1:0][AW-1:0]   ch_addr,
    output logic [NCH-1:0][AW-1:0]   ch_amsk,
    output logic [NCH-1:0][IW-1:0]   ch_id,
    output chan_cfg_t [NCH-1:0]      ch_cfg,
    output logic [DW-1:0]            b_data,
    output logic [DW-1:0]            b_dmsk,
    output ctrl_t                    ctrl,
    input  logic [NCH-1:0]           flags,
    output logic [NCH-1:0]           flag_clr
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ch_addr[c] <= '0;
                ch_amsk[c] <= '0;
                ch_id[c]   <= '0;
                ch_cfg[c]  <= '0;
            end else if (wr) begin
                if (addr == reg_of(c, OFF_ADDR)) ch_addr[c] <= wdata[AW-1:0];
                if (addr == reg_of(c, OFF_AMSK)) ch_amsk[c] <= wdata[AW-1:0];
                if (addr == reg_of(c, OFF_ID))   ch_id[c]   <= wdata[IW-1:0];
                if (addr == reg_of(c, OFF_CFG))  ch_cfg[c]  <= chan_cfg_t'(wdata[CFG_W-1:0]);
            end
        end
        assign flag_clr[c] = wr && (addr == RA_FLAGS) && !wdata[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_data <= '0;
            b_dmsk <= '0;
            ctrl   <= '0;
        end else if (wr) begin
            if (addr == RA_BDATA) b_data <= wdata[DW-1:0];
            if (addr == RA_BDMSK) b_dmsk <= wdata[DW-1:0];
            if (addr == RA_CTRL)  ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == reg_of(c, OFF_ADDR)) rdata = RW'(ch_addr[c]);
            if (addr == reg_of(c, OFF_AMSK)) rdata = RW'(ch_amsk[c]);
            if (addr == reg_of(c, OFF_ID))   rdata = RW'(ch_id[c]);
            if (addr == reg_of(c, OFF_CFG))  rdata = RW'(ch_cfg[c]);
        end
        if (addr == RA_BDATA) rdata = RW'(b_data);
        if (addr == RA_BDMSK) rdata = RW'(b_dmsk);
        if (addr == RA_CTRL)  rdata = RW'(ctrl);
        if (addr == RA_FLAGS) rdata = RW'(flags);
    end

endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int IW       = 8,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [IW-1:0] bus_id,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] cmp_amsk,
    input  logic [IW-1:0] cmp_id,
    input  chan_cfg_t     cfg,
    input  logic [DW-1:0] cmp_data,
    input  logic [DW-1:0] cmp_dmsk,
    input  logic          data_en,
    output logic          hit
);

    logic addr_ok, id_ok, data_ok;

    assign addr_ok = (((bus_addr ^ cmp_addr) & ~cmp_amsk) == '0);
    assign id_ok   = cfg.id_ign || (bus_id == cmp_id);

    if (HAS_DATA) begin : g_data
        logic use_data;
        assign use_data = data_en && !bus_fetch;
        assign data_ok  = !use_data || (((bus_data ^ cmp_data) & ~cmp_dmsk) == '0);
    end else begin : g_nodata
        logic unused_data;
        assign unused_data = ^{bus_data, cmp_data, cmp_dmsk, data_en};
        assign data_ok     = 1'b1;
    end

    assign hit = bus_valid && kind_ok(cfg, bus_fetch, bus_write) && addr_ok && id_ok && data_ok;

endmodule

// File: rtl/brk_seq.sv
module brk_seq
    import brk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hit_a,
    input  logic           hit_b,
    input  logic           bus_fetch,
    input  ctrl_t          ctrl,
    input  logic [NCH-1:0] flag_clr,
    output brk_tag_t       tag,
    output logic [NCH-1:0] flags,
    output logic           seen_a
);

    logic fire_a, fire_b_ind, fire_b_seq, fire_b, post_n;
    logic [NCH-1:0] flag_set;

    assign fire_a     = hit_a && !ctrl.seq;
    assign fire_b_ind = hit_b && !ctrl.seq;
    assign fire_b_seq = hit_b && ctrl.seq && seen_a;
    assign fire_b     = fire_b_ind || fire_b_seq;
    assign flag_set   = {fire_b, fire_a};

    always_comb begin
        if (!bus_fetch)  post_n = 1'b1;
        else if (fire_a) post_n = ctrl.post_a;
        else             post_n = ctrl.post_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag    <= '0;
            flags  <= '0;
            seen_a <= 1'b0;
        end else begin
            tag.req  <= fire_a || fire_b;
            tag.chan <= fire_a ? CH_A : CH_B;
            tag.post <= post_n;
            flags    <= flag_set | (flags & ~flag_clr);
            if (!ctrl.seq || fire_b_seq) seen_a <= 1'b0;
            else if (hit_a)              seen_a <= 1'b1;
        end
    end

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int RW = 32,
    parameter int AW = 32,
    parameter int IW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic            bus_valid,
    input  logic            bus_fetch,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [IW-1:0]   bus_id,
    input  logic [DW-1:0]   bus_data,
    output logic            brk_req,
    output logic            brk_chan,
    output logic            brk_post,
    output logic            flag_a,
    output logic            flag_b
);

    logic [NCH-1:0][AW-1:0] ch_addr, ch_amsk;
    logic [NCH-1:0][IW-1:0] ch_id;
    chan_cfg_t [NCH-1:0]    ch_cfg;
    logic [DW-1:0]          b_data, b_dmsk;
    ctrl_t                  ctrl;
    logic [NCH-1:0]         flags, flag_clr, hit;
    brk_tag_t               tag;
    logic                   seen_a;

    brk_regs #(.RW(RW), .AW(AW), .IW(IW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .ch_addr(ch_addr), .ch_amsk(ch_amsk), .ch_id(ch_id),
        .ch_cfg(ch_cfg), .b_data(b_data), .b_dmsk(b_dmsk), .ctrl(ctrl),
        .flags(flags), .flag_clr(flag_clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        brk_chan #(.AW(AW), .IW(IW), .DW(DW), .HAS_DATA(c == 1)) u_chan (
            .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_write(bus_write),
            .bus_addr(bus_addr), .bus_id(bus_id), .bus_data(bus_data),
            .cmp_addr(ch_addr[c]), .cmp_amsk(ch_amsk[c]), .cmp_id(ch_id[c]),
            .cfg(ch_cfg[c]), .cmp_data(b_data), .cmp_dmsk(b_dmsk),
            .data_en(ctrl.data_en), .hit(hit[c])
        );
    end

    brk_seq u_seq (
        .clk(clk), .rst(rst), .hit_a(hit[0]), .hit_b(hit[1]), .bus_fetch(bus_fetch),
        .ctrl(ctrl), .flag_clr(flag_clr), .tag(tag), .flags(flags), .seen_a(seen_a)
    );

    assign brk_req  = tag.req;
    assign brk_chan = tag.chan;
    assign brk_post = tag.post;
    assign flag_a   = flags[0];
    assign flag_b   = flags[1];

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk (
    input logic clk,
    input logic rst,
    input logic hit_a,
    input logic hit_b,
    input logic seq_on,
    input logic seen_a,
    input logic clr_a,
    input logic clr_b,
    input logic brk_req,
    input logic brk_chan,
    input logic flag_a,
    input logic flag_b
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!brk_req && !flag_a && !flag_b));

    p_no_hit_no_break_r6: assert property (@(posedge clk) disable iff (rst)
        (!hit_a && !hit_b) |=> !brk_req);

    p_break_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (flag_a || flag_b));

    p_flag_a_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !clr_a) |=> flag_a);

    p_flag_b_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_b && !clr_b) |=> flag_b);

    p_seq_needs_b_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_on && !hit_b) |=> !brk_req);

    p_seq_first_b_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_on && !seen_a) |=> !brk_req);

    p_seq_no_flag_a_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_on && !flag_a) |=> !flag_a);

    p_seq_reports_b_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_on && hit_b) |=> (!brk_req || brk_chan));

    p_seen_dropped_r11: assert property (@(posedge clk) disable iff (rst)
        !seq_on |=> !seen_a);

endmodule

bind brk_unit brk_unit_chk u_chk (
    .clk(clk), .rst(rst), .hit_a(hit[0]), .hit_b(hit[1]), .seq_on(ctrl.seq),
    .seen_a(seen_a), .clr_a(flag_clr[0]), .clr_b(flag_clr[1]),
    .brk_req(brk_req), .brk_chan(brk_chan), .flag_a(flag_a), .flag_b(flag_b)
);

// File: tb/sim_brk_unit.sv
module sim_brk_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_id = '0;
    logic [31:0] bus_data = '0;
    logic        brk_req, brk_chan, brk_post, flag_a, flag_b;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    brk_unit u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // one valid bus cycle; returns at the negedge after it, when the tag is visible
    task automatic cyc(input bit f, input bit w, input logic [31:0] a, input logic [7:0] id, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_addr = a; bus_id = id; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic expect_brk(input string req, input bit req_e, input bit ch_e, input bit post_e);
        chk(brk_req == req_e, req, {31'b0, brk_req}, {31'b0, req_e});
        if (req_e) begin
            chk(brk_chan == ch_e, req, {31'b0, brk_chan}, {31'b0, ch_e});
            chk(brk_post == post_e, req, {31'b0, brk_post}, {31'b0, post_e});
        end
    endtask

    task automatic set_chan(input int c, input logic [31:0] a, input logic [31:0] m,
                            input logic [7:0] id, input logic [4:0] cfg);
        wr(4'(c * 4 + 0), a);
        wr(4'(c * 4 + 1), m);
        wr(4'(c * 4 + 2), {24'b0, id});
        wr(4'(c * 4 + 3), {27'b0, cfg});
    endtask

    task automatic quiesce();
        wr(4'd3, 0); wr(4'd7, 0); wr(4'd10, 0); wr(4'd11, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(!brk_req && !flag_a && !flag_b, "R1 outputs",
            {29'b0, brk_req, flag_b, flag_a}, 0);
        for (int i = 0; i < 12; i++) begin
            rd(4'(i), v);
            chk(v == 0, "R1 register zero", v, 0);
        end
        cyc(1, 0, 0, 0, 0);
        expect_brk("R1 disabled after reset", 0, 0, 0);
        chk(!flag_a && !flag_b, "R1 no flag", {30'b0, flag_b, flag_a}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(4'd0, 32'h1234_5678); rd(4'd0, v);
        chk(v == 32'h1234_5678, "R13 address", v, 32'h1234_5678);
        wr(4'd9, 32'hA5A5_0F0F); rd(4'd9, v);
        chk(v == 32'hA5A5_0F0F, "R13 data mask", v, 32'hA5A5_0F0F);
        wr(4'd7, 32'hFF); rd(4'd7, v);
        chk(v == 32'h1F, "R13 config width", v, 32'h1F);
        wr(4'd10, 32'hFF); rd(4'd10, v);
        chk(v == 32'hF, "R13 control width", v, 32'hF);
        wr(4'd6, 32'h1FF); rd(4'd6, v);
        chk(v == 32'hFF, "R13 id width", v, 32'hFF);
        quiesce();
        wr(4'd9, 0);
    endtask

    task automatic t_kind();
        set_chan(0, 32'h1000, 0, 8'd5, 5'b0_01_01); // fetch, read
        cyc(1, 0, 32'h1000, 5, 0); expect_brk("R2 fetch read hit", 1, 0, 0);
        @(negedge clk);
        chk(!brk_req, "R6 single-cycle pulse", {31'b0, brk_req}, 0);
        cyc(0, 0, 32'h1000, 5, 0); expect_brk("R2 data access excluded", 0, 0, 0);
        cyc(1, 1, 32'h1000, 5, 0); expect_brk("R2 write excluded", 0, 0, 0);
        wr(4'd3, {27'b0, 5'b0_00_11});
        cyc(1, 0, 32'h1000, 5, 0); expect_brk("R2 direction 00 disables", 0, 0, 0);
        wr(4'd3, {27'b0, 5'b0_11_00});
        cyc(1, 0, 32'h1000, 5, 0); expect_brk("R2 cycle 00 disables", 0, 0, 0);
        wr(4'd3, {27'b0, 5'b0_10_10});
        cyc(0, 1, 32'h1000, 5, 0); expect_brk("R2 data write hit", 1, 0, 1);
        quiesce();
    endtask

    task automatic t_mask_id();
        set_chan(0, 32'h1000, 32'hF, 8'd5, 5'b0_11_11);
        cyc(1, 0, 32'h100A, 5, 0); expect_brk("R3 masked bits ignored", 1, 0, 0);
        cyc(1, 0, 32'h1010, 5, 0); expect_brk("R3 unmasked bit compared", 0, 0, 0);
        cyc(1, 0, 32'h1000, 6, 0); expect_brk("R4 id mismatch", 0, 0, 0);
        wr(4'd3, {27'b0, 5'b1_11_11});
        cyc(1, 0, 32'h1000, 6, 0); expect_brk("R4 id ignored", 1, 0, 0);
        quiesce();
    endtask

    task automatic t_tag();
        set_chan(0, 32'h40, 0, 0, 5'b0_11_11);
        set_chan(1, 32'h80, 0, 0, 5'b0_11_11);
        wr(4'd10, 32'h1); // post A
        cyc(1, 0, 32'h40, 0, 0); expect_brk("R7 fetch post A", 1, 0, 1);
        cyc(1, 0, 32'h80, 0, 0); expect_brk("R7 fetch pre B", 1, 1, 0);
        wr(4'd10, 32'h2); // post B
        cyc(1, 0, 32'h40, 0, 0); expect_brk("R7 fetch pre A", 1, 0, 0);
        cyc(1, 0, 32'h80, 0, 0); expect_brk("R7 fetch post B", 1, 1, 1);
        cyc(0, 0, 32'h40, 0, 0); expect_brk("R7 data access is post", 1, 0, 1);
        quiesce();
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        set_chan(0, 32'h40, 0, 0, 5'b0_11_11);
        cyc(1, 0, 32'h40, 0, 0);
        chk(flag_a && !flag_b, "R8 flag A set", {30'b0, flag_b, flag_a}, 1);
        cyc(1, 0, 32'h44, 0, 0);
        chk(flag_a, "R8 miss keeps flag", {31'b0, flag_a}, 1);
        wr(4'd11, 32'h3); rd(4'd11, v);
        chk(v == 1, "R8 write one no effect", v, 1);
        wr(4'd11, 32'h0); rd(4'd11, v);
        chk(v == 0, "R8 write zero clears", v, 0);
        @(negedge clk); // clearing write and match in one cycle
        reg_wr = 1'b1; reg_addr = 4'd11; reg_wdata = 0;
        bus_valid = 1'b1; bus_fetch = 1'b1; bus_write = 1'b0; bus_addr = 32'h40;
        @(negedge clk);
        reg_wr = 1'b0; bus_valid = 1'b0;
        chk(flag_a, "R8 set wins over clear", {31'b0, flag_a}, 1);
        quiesce();
    endtask

    task automatic t_data();
        set_chan(1, 32'h300, 0, 0, 5'b0_11_11);
        wr(4'd8, 32'hCAFE_0000);
        wr(4'd9, 32'h0000_FFFF);
        wr(4'd10, 32'h4);
        cyc(0, 1, 32'h300, 0, 32'hCAFE_1234); expect_brk("R5 data match under mask", 1, 1, 1);
        cyc(0, 1, 32'h300, 0, 32'hBEEF_0000); expect_brk("R5 data mismatch", 0, 0, 0);
        cyc(1, 0, 32'h300, 0, 32'hBEEF_0000); expect_brk("R5 fetch ignores data", 1, 1, 0);
        wr(4'd10, 32'h0);
        cyc(0, 0, 32'h300, 0, 32'hBEEF_0000); expect_brk("R5 data disabled", 1, 1, 1);
        quiesce();
        wr(4'd9, 0);
    endtask

    task automatic t_both();
        set_chan(0, 32'h500, 0, 0, 5'b0_11_11);
        set_chan(1, 32'h500, 0, 0, 5'b0_11_11);
        cyc(0, 0, 32'h500, 0, 0); expect_brk("R12 both match, A reported", 1, 0, 1);
        chk(flag_a && flag_b, "R12 both flags", {30'b0, flag_b, flag_a}, 3);
        @(negedge clk);
        chk(!brk_req, "R12 single pulse", {31'b0, brk_req}, 0);
        quiesce();
    endtask

    task automatic t_seq();
        set_chan(0, 32'h100, 0, 0, 5'b0_01_01);
        set_chan(1, 32'h200, 0, 0, 5'b0_01_01);
        wr(4'd10, 32'h8);
        cyc(1, 0, 32'h200, 0, 0); expect_brk("R9 B before A", 0, 0, 0);
        cyc(1, 0, 32'h100, 0, 0); expect_brk("R10 A never breaks", 0, 0, 0);
        chk(!flag_a, "R10 flag A stays low", {31'b0, flag_a}, 0);
        cyc(1, 0, 32'h200, 0, 0); expect_brk("R9 B after A", 1, 1, 0);
        chk(flag_b && !flag_a, "R10 only flag B", {30'b0, flag_b, flag_a}, 2);
        cyc(1, 0, 32'h200, 0, 0); expect_brk("R11 cleared by chained break", 0, 0, 0);
        cyc(1, 0, 32'h100, 0, 0);
        wr(4'd10, 32'h0); wr(4'd10, 32'h8);
        cyc(1, 0, 32'h200, 0, 0); expect_brk("R11 cleared by mode off", 0, 0, 0);
        wr(4'd4, 32'h100);
        cyc(1, 0, 32'h100, 0, 0); expect_brk("R9 same cycle no break", 0, 0, 0);
        cyc(1, 0, 32'h100, 0, 0); expect_brk("R9 later cycle breaks", 1, 1, 0);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_kind();
        t_mask_id();
        t_tag();
        t_sticky();
        t_data();
        t_both();
        t_seq();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule